// File: doc/BRIEF.md
# Protection-Aware Image Checksum Engine

This engine produces a 16-bit checksum over a stored program image. After a start pulse it reads the configuration word first. The code-protect bit of that word selects how the rest of the sum is built.

With protection off, the engine adds every user word. With protection on, it adds no user word. It builds one word from the low nibble of each of the four user-ID locations and adds that word instead. In both modes the configuration word is added after a fixed mask clears its unused bits.

The engine drives a synchronous read port and issues one address per cycle. The memory returns data one cycle after the address. The result appears on a plain output, and a one-cycle done pulse marks it valid.

Top module: `image_checksum`

## Requirements
- R1: While reset is held and right after it, busy, done, mem_rd and checksum are all 0.
- R2: The code-protect bit is bit 6 of the configuration word, which is read at address 0x2007. When that bit is 1, the result is the 16-bit sum of the user words at 0x0000 to 0x0FFF plus (configuration word AND 0x2D78). Carries above bit 15 are dropped.
- R3: When bit 6 is 0, the result is (configuration word AND 0x2D78) plus a packed word. In the packed word, bits 15:12 are bits 3:0 of address 0x2000, bits 11:8 come from 0x2001, bits 7:4 from 0x2002 and bits 3:0 from 0x2003. The ID bits above bit 3 have no effect.
- R4: Configuration-word bits outside the mask 0x2D78 have no effect on the result.
- R5: In protected mode no address below 0x2000 is read.
- R6: done is high for exactly one cycle. It rises N+3 rising edges after the edge that samples start, where N is 4096 when unprotected and 4 when protected.
- R7: busy rises on the edge after start is sampled and falls on the edge where done rises. busy and done are never high together.
- R8: checksum keeps its value from the done pulse until a new start is accepted.
- R9: A start pulse while busy is ignored. Both the result and the done timing stay as they would be without it.
- R10: The first read of every run is address 0x2007. Every read targets a user word, a user-ID location or 0x2007.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a checksum run; sampled only when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: checksum is valid |
| checksum | output | 16 | Result, held until the next start |
| mem_rd | output | 1 | Read strobe toward the image memory |
| mem_addr | output | 14 | Read address |
| mem_rdata | input | 14 | Read data, valid one cycle after mem_rd |

## Verification
Counting from the edge that samples start, the configuration read takes two cycles and the scan takes one cycle per word. The final add takes one more cycle, so done is due N+3 edges later. That is 4099 edges unprotected and 7 edges protected. Busy is due high one edge after start.

The bench drives start at a falling edge and counts falling edges until it sees done. It then compares that count with the exact figure. It reads done and checksum at the falling edge where the pulse is high, and once more one cycle later, to confirm the pulse has ended and the value holds.

// File: rtl/csum_pkg.sv
// Shared types for the image checksum engine.
// Assumes: nothing beyond IEEE 1800-2017.
package csum_pkg;

    // Run phases of the read sequencer
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,   // waiting for start
        PH_CFGREQ = 3'd1,   // configuration word address on the port
        PH_CFGGET = 3'd2,   // configuration word returning
        PH_SCAN   = 3'd3,   // one image address per cycle
        PH_DRAIN  = 3'd4    // last word returning
    } phase_t;

endpackage

// File: rtl/csum_sequencer.sv
// Read sequencer: walks the configuration word, then either all user
// words or the user-ID locations, one address per cycle.
// Assumes: memory data valid exactly one cycle after the address, and
// ID_COUNT <= USER_WORDS.
module csum_sequencer
    import csum_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int USER_WORDS = 4096,
    parameter int ID_COUNT   = 4,
    parameter logic [ADDR_W-1:0] ID_BASE  = 14'h2000,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 14'h2007,
    localparam int IDX_W = $clog2(USER_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              prot_bit_in,   // protect bit of returning data
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cfg_load,      // returning data is the config word
    output logic              word_valid,    // returning data is an image word
    output logic [IDX_W-1:0]  word_idx,      // index of the returning word
    output logic              protected_q,   // run uses the packed-ID method
    output logic              run_busy,
    output logic              run_done
);

    phase_t           phase_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;

    // Final scan index for the method picked in this run
    always_comb last_idx = protected_q ? IDX_W'(ID_COUNT - 1) : IDX_W'(USER_WORDS - 1);

    // Phase progression and scan index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            idx_q       <= '0;
            protected_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE:   if (start) phase_q <= PH_CFGREQ;
                PH_CFGREQ: phase_q <= PH_CFGGET;
                PH_CFGGET: begin
                    protected_q <= ~prot_bit_in;
                    idx_q       <= '0;
                    phase_q     <= PH_SCAN;
                end
                PH_SCAN: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == last_idx) phase_q <= PH_DRAIN;
                end
                PH_DRAIN:  phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    // Track which returning word matches each issued read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_idx   <= '0;
            run_done   <= 1'b0;
        end else begin
            word_valid <= (phase_q == PH_SCAN);
            word_idx   <= idx_q;
            run_done   <= (phase_q == PH_DRAIN);
        end
    end

    // Read strobe and address for the current phase
    always_comb begin
        rd_en   = (phase_q == PH_CFGREQ) || (phase_q == PH_SCAN);
        rd_addr = '0;
        if (phase_q == PH_CFGREQ)
            rd_addr = CFG_ADDR;
        else if (phase_q == PH_SCAN)
            rd_addr = protected_q ? (ID_BASE + ADDR_W'(idx_q)) : ADDR_W'(idx_q);
    end

    // Status toward the top
    always_comb begin
        cfg_load = (phase_q == PH_CFGGET);
        run_busy = (phase_q != PH_IDLE);
    end

endmodule

// File: rtl/csum_accum.sv
// Checksum accumulator: loads the masked configuration word, then adds
// either raw user words or ID nibbles placed at their packed position.
// Assumes: NIB_W*ID_COUNT <= SUM_W; wraps modulo 2**SUM_W.
module csum_accum #(
    parameter int WORD_W     = 14,
    parameter int SUM_W      = 16,
    parameter int USER_WORDS = 4096,
    parameter int ID_COUNT   = 4,
    parameter int NIB_W      = 4,
    parameter logic [SUM_W-1:0] CFG_MASK = 16'h2D78,
    localparam int IDX_W = $clog2(USER_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              word_valid,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic              protected_q,
    input  logic [WORD_W-1:0] rdata,
    output logic [SUM_W-1:0]  sum_q
);

    logic [SUM_W-1:0] data_ext;
    logic [SUM_W-1:0] nib_ext;
    logic [SUM_W-1:0] packed_term;
    logic [SUM_W-1:0] addend;

    // Widen the returning word and its low nibble
    always_comb begin
        data_ext = SUM_W'(rdata);
        nib_ext  = SUM_W'(rdata[NIB_W-1:0]);
    end

    // Place the nibble: the first ID goes to the top nibble
    always_comb begin
        packed_term = '0;
        for (int k = 0; k < ID_COUNT; k++) begin
            if (word_idx == IDX_W'(k))
                packed_term = nib_ext << (NIB_W * (ID_COUNT - 1 - k));
        end
    end

    // Select the term for the active method
    always_comb addend = protected_q ? packed_term : data_ext;

    // Running sum register
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_q <= '0;
        else if (cfg_load)
            sum_q <= data_ext & CFG_MASK;
        else if (word_valid)
            sum_q <= sum_q + addend;
    end

endmodule

// File: rtl/image_checksum.sv
// Top of the protection-aware image checksum engine. It joins the read
// sequencer and the accumulator, and exposes a start/busy/done handshake
// and a synchronous read port.
// Assumes: memory returns data one cycle after mem_rd; start is ignored
// while busy.
module image_checksum #(
    parameter int ADDR_W     = 14,
    parameter int WORD_W     = 14,
    parameter int SUM_W      = 16,
    parameter int USER_WORDS = 4096,
    parameter int ID_COUNT   = 4,
    parameter int NIB_W      = 4,
    parameter int PROT_BIT   = 6,
    parameter logic [ADDR_W-1:0] ID_BASE  = 14'h2000,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 14'h2007,
    parameter logic [SUM_W-1:0]  CFG_MASK = 16'h2D78
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [SUM_W-1:0]  checksum,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata
);

    localparam int IDX_W = $clog2(USER_WORDS);

    logic             cfg_load;
    logic             word_valid;
    logic [IDX_W-1:0] word_idx;
    logic             protected_q;

    csum_sequencer #(
        .ADDR_W(ADDR_W), .USER_WORDS(USER_WORDS), .ID_COUNT(ID_COUNT),
        .ID_BASE(ID_BASE), .CFG_ADDR(CFG_ADDR)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .prot_bit_in(mem_rdata[PROT_BIT]),
        .rd_en(mem_rd), .rd_addr(mem_addr),
        .cfg_load(cfg_load), .word_valid(word_valid), .word_idx(word_idx),
        .protected_q(protected_q), .run_busy(busy), .run_done(done)
    );

    csum_accum #(
        .WORD_W(WORD_W), .SUM_W(SUM_W), .USER_WORDS(USER_WORDS),
        .ID_COUNT(ID_COUNT), .NIB_W(NIB_W), .CFG_MASK(CFG_MASK)
    ) acc_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .word_valid(word_valid), .word_idx(word_idx),
        .protected_q(protected_q), .rdata(mem_rdata), .sum_q(checksum)
    );

endmodule

// File: rtl/image_checksum_checker.sv
// Port-level protocol checks for image_checksum, attached by bind.
// Assumes: the same parameter values as the bound instance.
module image_checksum_checker #(
    parameter int ADDR_W     = 14,
    parameter int SUM_W      = 16,
    parameter int USER_WORDS = 4096,
    parameter int ID_COUNT   = 4,
    parameter logic [ADDR_W-1:0] ID_BASE  = 14'h2000,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 14'h2007
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [SUM_W-1:0]  checksum,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr
);

    // R6: the done pulse lasts one cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: busy and done never overlap
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R7: done follows a busy cycle
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R8: checksum holds while idle with no start
    assert_sum_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(checksum));

    // R9: a start while busy does not end the run early or restart it
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R10: the first read of a run is the configuration word
    assert_cfg_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_rd && mem_addr == CFG_ADDR));

    // R10: every read targets a legal location
    assert_addr_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ((mem_addr < ADDR_W'(USER_WORDS)) ||
                    (mem_addr >= ID_BASE && mem_addr < ID_BASE + ADDR_W'(ID_COUNT)) ||
                    (mem_addr == CFG_ADDR)));

    // R1: no read strobe while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd);

endmodule

bind image_checksum image_checksum_checker #(
    .ADDR_W(ADDR_W), .SUM_W(SUM_W), .USER_WORDS(USER_WORDS),
    .ID_COUNT(ID_COUNT), .ID_BASE(ID_BASE), .CFG_ADDR(CFG_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .checksum(checksum), .mem_rd(mem_rd), .mem_addr(mem_addr)
);

// File: tb/image_checksum_tb_top.sv
// Directed bench for image_checksum with a behavioural image memory.
module image_checksum_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, mem_rd;
    logic [15:0] checksum;
    logic [13:0] mem_addr;
    logic [13:0] mem_rdata;

    logic [13:0] user_mem [4096];
    logic [13:0] id_mem [4];
    logic [13:0] cfg_word;
    logic        low_read_seen;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc_total = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    image_checksum dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .checksum(checksum), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    // Image memory with one-cycle read latency
    always_ff @(posedge clk) begin
        if (mem_rd) begin
            if (mem_addr < 14'h1000)      mem_rdata <= user_mem[mem_addr[11:0]];
            else if (mem_addr == 14'h2007) mem_rdata <= cfg_word;
            else if (mem_addr >= 14'h2000 && mem_addr < 14'h2004)
                                          mem_rdata <= id_mem[mem_addr[1:0]];
            else                          mem_rdata <= 14'h0;
            if (mem_addr < 14'h2000) low_read_seen <= 1'b1;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc_total);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [13:0] cfg);
        logic [15:0] s;
        s = {2'b0, cfg} & 16'h2D78;
        if (cfg[6]) begin
            for (int i = 0; i < 4096; i++) s = s + {2'b0, user_mem[i]};
        end else begin
            s = s + {id_mem[0][3:0], id_mem[1][3:0], id_mem[2][3:0], id_mem[3][3:0]};
        end
        return s;
    endfunction

    // Start one run; optionally pulse start again mid-run. Returns
    // the latency in edges and the sampled result.
    task automatic run(input int extra_start_at, output int lat, output logic [15:0] res,
                       output bit busy_ok);
        low_read_seen = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 0; busy_ok = 1'b1;
        while (1) begin
            if (lat == extra_start_at) start = 1'b1;
            @(negedge clk); start = 1'b0;
            lat++;
            if (done) break;
            if (!busy) busy_ok = 1'b0;
            if (lat > 5000) break;
        end
        res = checksum;
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0 && mem_rd == 0, "R1 idle flags", {busy, done, mem_rd}, 0);
        chk(checksum == 16'h0, "R1 checksum", checksum, 0);
    endtask

    task automatic t_blank();
        int lat; logic [15:0] r; bit bo;
        foreach (user_mem[i]) user_mem[i] = 14'h3FFF;
        foreach (id_mem[i]) id_mem[i] = 14'h3FFF;
        cfg_word = 14'h3FFF;
        run(-1, lat, r, bo);
        chk(r == 16'h1D78, "R2 blank image", r, 16'h1D78);
        chk(lat == 4099, "R6 unprotected latency", lat, 4099);
        chk(bo, "R7 busy through run", bo, 1);
        chk(busy == 0, "R7 busy low with done", busy, 0);
        @(negedge clk);
        chk(done == 0, "R6 done one cycle", done, 0);
        repeat (5) @(negedge clk);
        chk(checksum == 16'h1D78, "R8 checksum held", checksum, 16'h1D78);
    endtask

    task automatic t_pattern();
        int lat; logic [15:0] r; bit bo; logic [15:0] e;
        foreach (user_mem[i]) user_mem[i] = 14'((i * 37 + 5) ^ (i >> 3));
        cfg_word = 14'h1FC7;     // bit 6 set, several unmasked bits set
        e = model(cfg_word);
        run(-1, lat, r, bo);
        chk(r == e, "R2 patterned image", r, e);
    endtask

    task automatic t_mask();
        int lat; logic [15:0] r1, r2; bit bo;
        cfg_word = 14'h3FFF;
        run(-1, lat, r1, bo);
        cfg_word = 14'h2D78;
        run(-1, lat, r2, bo);
        chk(r1 == r2, "R4 unmasked config bits ignored", r2, r1);
    endtask

    task automatic t_protected_example();
        int lat; logic [15:0] r; bit bo;
        id_mem[0] = 14'd6; id_mem[1] = 14'd7; id_mem[2] = 14'd1; id_mem[3] = 14'd2;
        cfg_word = 14'h3FBF;
        run(-1, lat, r, bo);
        chk(r == 16'h944A, "R3 protected example", r, 16'h944A);
        chk(lat == 7, "R6 protected latency", lat, 7);
        chk(!low_read_seen, "R5 no user reads when protected", low_read_seen, 0);
    endtask

    task automatic t_protected_order();
        int lat; logic [15:0] r; bit bo;
        id_mem[0] = 14'h3FF1; id_mem[1] = 14'h2A52; id_mem[2] = 14'h1003; id_mem[3] = 14'h0ED4;
        cfg_word = 14'h0000;     // protected, mask term zero
        run(-1, lat, r, bo);
        chk(r == 16'h1234, "R3 nibble order and upper ID bits", r, 16'h1234);
    endtask

    task automatic t_restart_ignored();
        int lat; logic [15:0] r; bit bo;
        cfg_word = 14'h3FBF;
        id_mem[0] = 14'd9; id_mem[1] = 14'd8; id_mem[2] = 14'd7; id_mem[3] = 14'd6;
        run(3, lat, r, bo);
        chk(lat == 7, "R9 start while busy keeps timing", lat, 7);
        chk(r == 16'h2D38 + 16'h9876, "R9 start while busy keeps result", r, 16'h2D38 + 16'h9876);
        @(negedge clk);
        chk(busy == 0, "R9 no second run", busy, 0);
    endtask

    initial begin
        low_read_seen = 1'b0;
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_blank();
        t_pattern();
        t_mask();
        t_protected_example();
        t_protected_order();
        t_restart_ignored();
        finish_run();
    end

endmodule